// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 10-bit successive-approximation converter. It divides the system clock by 16, 32 or 64 to form the conversion clock period (TAD). One conversion takes eleven TAD periods. The first ten TADs each resolve one bit, starting from the most significant. The last TAD moves the finished code into a pair of result registers. When a conversion ends normally, the start/busy bit clears and a completion flag is set. The comparator and DAC stay outside the block. The block drives the trial code on `trial`, and the comparator answers on `cmp_ge`.

Software starts a conversion by pulsing `start_set`. It can stop one by pulsing `start_clr`. A stop that arrives before every bit is resolved throws the conversion away. A stop that arrives during the eleventh TAD still keeps the finished code. This lets software end a conversion early by its own timing and still get a valid result.

Top module: `sar_conv_seq`

## Requirements
- R1: After a `start_set` pulse while idle, `busy` goes high at the next edge. With no stop request, `busy` stays high for exactly 11 × D system clocks, where D is the divisor.
- R2: `div_sel` selects the divisor D. The encoding is 0 → 16, 1 → 32, and 2 or 3 → 64. The value is captured when the conversion starts, so changing `div_sel` during a conversion has no effect on its length.
- R3: Bits are tried MSB first, one bit per TAD over the first ten TADs. `trial` shows the bits already decided plus the bit under test. `cmp_ge` is sampled on the last clock of each of those TADs, and the bit under test is kept when `cmp_ge` is 1. If the comparator reports whether the sample is at or above `trial`, the result equals the sample.
- R4: At normal completion, `busy` clears, `done_flag` is set and the result is loaded right-justified. `res_hi[1:0]` holds result bits 9:8, `res_hi[7:2]` is 0, and `res_lo[7:0]` holds result bits 7:0.
- R5: `done_flag` stays set until a `flag_clr` pulse clears it.
- R6: A `start_clr` pulse during the first ten TADs clears `busy` at the next edge. It leaves `res_hi`/`res_lo` unchanged and does not set `done_flag`.
- R7: A `start_clr` pulse during the eleventh TAD clears `busy` at the next edge and loads the full, correct result. It does not set `done_flag`.
- R8: A `start_set` pulse while `busy` is high has no effect: the conversion length and the result do not change.
- R9: A `start_clr` pulse while idle has no effect on `busy`, `done_flag` or the result registers.
- R10: After reset, `busy`, `done_flag`, `res_hi`, `res_lo` and `trial` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | TAD divisor select (0:16, 1:32, 2/3:64) |
| start_set | input | 1 | Pulse: software sets the start bit |
| start_clr | input | 1 | Pulse: software clears the start bit |
| flag_clr | input | 1 | Pulse: clear the completion flag |
| cmp_ge | input | 1 | Comparator: sample is at or above `trial` |
| trial | output | 10 | Trial code to the DAC |
| busy | output | 1 | Start/busy bit |
| done_flag | output | 1 | Completion (interrupt) flag |
| res_hi | output | 8 | Result high register, upper 2 bits right-justified |
| res_lo | output | 8 | Result low register, lower 8 bits |

## Verification
The assertions assume that `cmp_ge` answers the current `trial` combinationally and stays consistent within a TAD. They also assume that `start_set` and `start_clr` are single-cycle pulses that are never raised together. The stimulus meets these assumptions as follows. A fixed analog sample is held for each conversion and compared against `trial` to produce `cmp_ge`. Every control pulse is driven on a falling edge and lasts one cycle. The stop pulses are placed at chosen offsets just before and inside the eleventh TAD.

// File: rtl/sar_seq_pkg.sv
// Shared constants and the divisor decode for the conversion sequencer.
// Assumes a two-bit divisor select; unused code 3 maps to the slowest rate.
package sar_seq_pkg;
    localparam int DIV_MAX = 64;

    // Map the select code to a system-clock divisor.
    function automatic int tad_div_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 32;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/sar_tad_div.sv
// TAD divider: counts system clocks while a conversion runs and pulses
// tick on the last clock of every TAD. Assumes div_m1 is held constant
// while run is high.
module sar_tad_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div_m1,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == div_m1);

    // Count within a TAD; restart at each tick and whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // R1: the count never passes the captured divisor during a run
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div_m1));
endmodule

// File: rtl/sar_bits.sv
// Successive-approximation register: holds decided bits, presents the
// current trial (decided bits plus the bit under test) and keeps the bit
// under test when the comparator reports at-or-above. Assumes step pulses
// only while active.
module sar_bits #(
    parameter int RES_W = 10,
    parameter int PH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             step,
    input  logic [PH_W-1:0]  phase,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] code
);
    logic [RES_W-1:0] probe;

    // One probe bit per position: phase 0 tests the MSB.
    for (genvar i = 0; i < RES_W; i++) begin : g_probe
        assign probe[i] = active && (phase == PH_W'(RES_W - 1 - i));
    end

    assign trial = code | probe;

    // Clear at start; on each trial tick keep the probe bit if accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)               code <= '0;
        else if (clear)           code <= '0;
        else if (step && cmp_ge)  code <= code | probe;
    end

    // R3: a rejected trial leaves the decided bits untouched
    a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        step && !cmp_ge && !clear |=> $stable(code));
    // R3: an accepted trial sets the tested bit
    a_r3_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
        step && cmp_ge && !clear && (probe != '0) |=> ((code & $past(probe)) == $past(probe)));
endmodule

// File: rtl/sar_conv_seq.sv
// Conversion sequencer top: accepts start/stop pulses, runs eleven TADs
// (ten bit trials plus a transfer TAD), loads the right-justified result
// and sets the completion flag. Assumes start_set and start_clr are not
// pulsed in the same cycle.
module sar_conv_seq #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       div_sel,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             flag_clr,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial,
    output logic             busy,
    output logic             done_flag,
    output logic [REG_W-1:0] res_hi,
    output logic [REG_W-1:0] res_lo
);
    import sar_seq_pkg::*;

    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam int PH_W    = $clog2(RES_W + 1);
    localparam int HI_BITS = RES_W - REG_W;
    localparam int PAD_W   = REG_W - HI_BITS;

    logic [CNT_W-1:0] div_m1;
    logic [PH_W-1:0]  phase;
    logic [RES_W-1:0] code;
    logic             tick, accept, last, abort, keep, step;

    assign accept = start_set && !busy;
    assign last   = busy && tick && (phase == PH_W'(RES_W));
    assign abort  = busy && start_clr && !last;
    assign keep   = abort && (phase == PH_W'(RES_W));
    assign step   = busy && tick && (phase < PH_W'(RES_W));

    sar_tad_div #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .div_m1 (div_m1),
        .tick   (tick)
    );

    sar_bits #(.RES_W(RES_W), .PH_W(PH_W)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .active (busy),
        .step   (step),
        .phase  (phase),
        .cmp_ge (cmp_ge),
        .trial  (trial),
        .code   (code)
    );

    // Sequencer state: start, phase advance, completion and stop handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            phase  <= '0;
            div_m1 <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            phase  <= '0;
            div_m1 <= CNT_W'(tad_div_of(div_sel) - 1);
        end else if (last || abort) begin
            busy   <= 1'b0;
        end else if (busy && tick) begin
            phase  <= phase + 1'b1;
        end
    end

    // Result registers: loaded at completion or at a stop after all bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (last || keep) begin
            res_hi <= {{PAD_W{1'b0}}, code[RES_W-1:REG_W]};
            res_lo <= code[REG_W-1:0];
        end
    end

    // Completion flag: set by normal completion, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (last)     done_flag <= 1'b1;
        else if (flag_clr) done_flag <= 1'b0;
    end

    // R4: the flag only rises together with the end of a conversion
    a_r4_flag_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));
    // R8: without a stop or the final tick, a running conversion keeps going
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start_clr && !(tick && phase == PH_W'(RES_W)) |=> busy);
    // R6: an early stop leaves the result registers unchanged
    a_r6_discard_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_clr && (phase < PH_W'(RES_W)) |=> ($stable(res_hi) && $stable(res_lo) && !$rose(done_flag)));
    // R1: the phase never runs past the transfer TAD
    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase <= PH_W'(RES_W)));
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       start_set = 1'b0, start_clr = 1'b0, flag_clr = 1'b0;
    logic [9:0] sample = 10'd0;
    logic       cmp_ge;
    logic [9:0] trial;
    logic       busy, done_flag;
    logic [7:0] res_hi, res_lo;

    int checks = 0, fails = 0;
    bit ended = 0;
    logic [9:0] exp_res = 10'd0;

    always #4 clk = ~clk;

    assign cmp_ge = (sample >= trial);

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .start_set(start_set),
        .start_clr(start_clr), .flag_clr(flag_clr), .cmp_ge(cmp_ge),
        .trial(trial), .busy(busy), .done_flag(done_flag),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic int div_of(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // Run one conversion; stop_at/restart_at are cycle offsets (-1 = none).
    task automatic convert(input logic [9:0] s, input logic [1:0] sel,
                           input int stop_at, input int restart_at, input string req);
        int n;
        int d;
        logic [9:0] prev;
        d = div_of(sel);
        prev = exp_res;
        clear_flag();
        sample = s; div_sel = sel; start_set = 1'b1;
        @(negedge clk); start_set = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            if (n == stop_at) start_clr = 1'b1;
            if (n == restart_at) begin start_set = 1'b1; div_sel = sel + 2'd1; end
            @(negedge clk);
            start_clr = 1'b0; start_set = 1'b0;
            n++;
        end
        if (stop_at < 0) begin
            exp_res = s;
            chk({req, " length"}, n, 11 * d);
            chk({req, " flag"}, int'(done_flag), 1);
        end else begin
            chk({req, " stop length"}, n, stop_at + 1);
            chk({req, " flag"}, int'(done_flag), 0);
            exp_res = (stop_at >= 10 * d) ? s : prev;
        end
        chk({req, " res_hi"}, int'(res_hi), int'({6'd0, exp_res[9:8]}));
        chk({req, " res_lo"}, int'(res_lo), int'(exp_res[7:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 flag", int'(done_flag), 0);
        chk("R10 res", int'({res_hi, res_lo}), 0);
        chk("R10 trial", int'(trial), 0);

        // R1 R2 R3 R4 directed values at each divisor
        convert(10'h3FF, 2'd0, -1, -1, "R1 R3 R4 full-scale div16");
        convert(10'h000, 2'd1, -1, -1, "R2 R3 zero div32");
        convert(10'h200, 2'd2, -1, -1, "R2 R3 midscale div64");
        convert(10'h155, 2'd3, -1, -1, "R2 R4 pattern sel3");

        // R5 flag held until cleared
        repeat (20) @(negedge clk);
        chk("R5 flag held", int'(done_flag), 1);
        clear_flag();
        chk("R5 flag cleared", int'(done_flag), 0);

        // R6 stop during the last trial TAD discards
        convert(10'h0AA, 2'd0, 10 * 16 - 1, -1, "R6 late discard");
        convert(10'h2C3, 2'd1, 40, -1, "R6 early discard");
        // R7 stop at 10.5 TAD keeps the result
        convert(10'h1E7, 2'd0, 10 * 16 + 8, -1, "R7 keep 10.5 TAD");
        convert(10'h321, 2'd1, 11 * 32 - 2, -1, "R7 keep near end");

        // R8 restart (and divisor change) while busy ignored
        convert(10'h0F0, 2'd0, -1, 50, "R8 restart ignored");

        // R9 stop while idle ignored
        @(negedge clk); start_clr = 1'b1;
        @(negedge clk); start_clr = 1'b0;
        @(negedge clk);
        chk("R9 busy", int'(busy), 0);
        chk("R9 flag", int'(done_flag), 1);
        chk("R9 res", int'({res_hi[1:0], res_lo}), int'(exp_res));

        // Random conversions
        for (int k = 0; k < 12; k++) begin
            convert(10'($urandom), 2'($urandom), -1, -1, "R3 R4 random");
        end
        summary();
    end
endmodule